// File: doc/BRIEF.md
# Cache Line Miss Refill Controller

This block runs the whole handling of one cache miss. It sits between the tag and data arrays of a cache and the memory level below it. A miss request carries three things: the missing address, the array slot picked as the victim (with its dirty flag), and the line address the victim currently holds. The controller then runs a fixed sequence. If the victim is dirty, it first streams the victim line out to the next level. It then requests the new line and waits a fixed latency. It collects the line as a series of bus beats and writes each beat into the data array. In the final cycle it commits the new tag entry and pulses `done` so the core can resume.

Every phase has a fixed cycle cost set by parameters. The miss penalty is therefore exact: with a 64-byte line on a 16-byte bus (four beats), two cycles per beat and a 10-cycle request latency, a clean miss takes 19 cycles from the request cycle to the fill cycle, both counted. A dirty miss adds one writeback request cycle plus four write beats. The controller accepts one miss at a time and holds `miss_ready` low until it has finished.

Top module: `miss_refill_ctrl`

## Requirements
- R1: After reset and whenever idle, `miss_ready` is 1. A request is accepted in a cycle where `miss_valid` and `miss_ready` are both 1. `miss_ready` is 0 from the next cycle until the cycle after `done`. A request presented and withdrawn while `miss_ready` is 0 has no effect, so no extra `nl_req` follows the current miss.
- R2: For a clean victim, `nl_req`=1 with `nl_we`=0 for exactly one cycle, the cycle after acceptance. `nl_addr` carries the line address `miss_addr[31:6]`.
- R3: The line arrives as LINE_BYTES/BUS_BYTES = 4 beats. Counting the read request cycle as cycle 0, `nl_rtake` pulses in cycles 11, 13, 15 and 17 (request latency 10, 2 cycles per beat, data taken in the second cycle of each beat). Beat k is sampled from `nl_rdata` in its take cycle.
- R4: Each beat is written to the data array in the cycle after its take. `dwr_en`=1, `dwr_slot` is the victim slot, and `dwr_word`=k counts 0,1,2,3 in ascending order. `dwr_data` is the sampled beat.
- R5: In read-request cycle 18, `done`=1 and `tag_we`=1 for one cycle, together with the write of beat 3. `tag_slot` is the victim slot, `tag_val`=`miss_addr[31:12]`, `tag_valid`=1 and `tag_dirty`=0. A clean miss therefore takes 19 cycles from request to fill, both counted.
- R6: For a dirty victim, the cycle after acceptance carries `nl_req`=1, `nl_we`=1 and `nl_addr`=`miss_vic_line`. Then follow 4 write beats of 2 cycles each. In the second cycle of beat k, `nl_wput`=1, `drd_word`=k, `drd_slot` is the victim slot and `nl_wdata` equals `drd_data`. The read request follows in the next cycle, so a dirty miss spans 28 cycles from writeback request to `done`, both counted.
- R7: `dwr_en` and `tag_we` stay 0 while idle and throughout the writeback, so the victim slot is not overwritten before its last write beat has been sent.
- R8: A request held on `miss_valid` during a busy period is accepted in the cycle after `done`, and its own sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Controller idle, request can be taken |
| miss_addr | input | ADDR_W | Missing byte address |
| miss_slot | input | SLOT_W | Array slot of the chosen victim |
| miss_dirty | input | 1 | Victim line holds modified data |
| miss_vic_line | input | ADDR_W-log2(LINE_BYTES) | Line address held by the victim |
| nl_req | output | 1 | Next-level request strobe |
| nl_we | output | 1 | Request is a writeback (1) or a line read (0) |
| nl_addr | output | ADDR_W-log2(LINE_BYTES) | Line address of the request |
| nl_wput | output | 1 | Writeback beat handed over this cycle |
| nl_wdata | output | BUS_BYTES*8 | Writeback beat data |
| nl_rtake | output | 1 | Refill beat taken from `nl_rdata` this cycle |
| nl_rdata | input | BUS_BYTES*8 | Refill beat data |
| drd_slot | output | SLOT_W | Data array read slot |
| drd_word | output | log2(LINE_BYTES/BUS_BYTES) | Data array read word offset |
| drd_data | input | BUS_BYTES*8 | Data array read data (combinational) |
| dwr_en | output | 1 | Data array write enable |
| dwr_slot | output | SLOT_W | Data array write slot |
| dwr_word | output | log2(LINE_BYTES/BUS_BYTES) | Data array write word offset |
| dwr_data | output | BUS_BYTES*8 | Data array write data |
| tag_we | output | 1 | Tag array write enable |
| tag_slot | output | SLOT_W | Tag array write slot |
| tag_val | output | ADDR_W-log2(LINE_BYTES)-SET_W | New tag |
| tag_valid | output | 1 | Valid bit written with the tag |
| tag_dirty | output | 1 | Dirty bit written with the tag |
| done | output | 1 | Miss finished, core may resume |

## Verification
The assertions assume that `nl_rdata` is valid whenever `nl_rtake` is high. They also assume that the data array answers `drd_slot`/`drd_word` combinationally in the same cycle, because the controller never waits on either. The bench's memory model keeps these assumptions. It presents beat data indexed by its own count of takes since the last read request, and it computes `drd_data` directly from the read address. Stimulus changes requests only on falling edges. It holds or withdraws `miss_valid` during busy periods to exercise hold-off, and it leaves the address fields stable from presentation through acceptance.

// File: rtl/miss_refill_ctrl.sv
module miss_refill_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int BUS_BYTES  = 16,
  parameter int SET_W      = 6,
  parameter int SLOT_W     = 8,
  parameter int REQ_LAT    = 10,
  parameter int BEAT_CYC   = 2
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       miss_valid,
  output logic                                       miss_ready,
  input  logic [ADDR_W-1:0]                          miss_addr,
  input  logic [SLOT_W-1:0]                          miss_slot,
  input  logic                                       miss_dirty,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]       miss_vic_line,
  output logic                                       nl_req,
  output logic                                       nl_we,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]       nl_addr,
  output logic                                       nl_wput,
  output logic [BUS_BYTES*8-1:0]                     nl_wdata,
  output logic                                       nl_rtake,
  input  logic [BUS_BYTES*8-1:0]                     nl_rdata,
  output logic [SLOT_W-1:0]                          drd_slot,
  output logic [$clog2(LINE_BYTES/BUS_BYTES)-1:0]    drd_word,
  input  logic [BUS_BYTES*8-1:0]                     drd_data,
  output logic                                       dwr_en,
  output logic [SLOT_W-1:0]                          dwr_slot,
  output logic [$clog2(LINE_BYTES/BUS_BYTES)-1:0]    dwr_word,
  output logic [BUS_BYTES*8-1:0]                     dwr_data,
  output logic                                       tag_we,
  output logic [SLOT_W-1:0]                          tag_slot,
  output logic [ADDR_W-$clog2(LINE_BYTES)-SET_W-1:0] tag_val,
  output logic                                       tag_valid,
  output logic                                       tag_dirty,
  output logic                                       done
);

  localparam int OFF_W   = $clog2(LINE_BYTES);
  localparam int LINE_W  = ADDR_W - OFF_W;
  localparam int TAG_W   = LINE_W - SET_W;
  localparam int BEATS   = LINE_BYTES / BUS_BYTES;
  localparam int WORD_W  = $clog2(BEATS);
  localparam int BW      = BUS_BYTES * 8;
  localparam int CNT_W   = $clog2(REQ_LAT + 1);
  localparam int SUB_W   = $clog2(BEAT_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_WREQ, S_WBEAT, S_RREQ, S_RBEAT, S_FILL} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [SUB_W-1:0]  sub;
  logic [WORD_W-1:0] beat;
  logic [LINE_W-1:0] r_line;
  logic [LINE_W-1:0] r_vline;
  logic [SLOT_W-1:0] r_slot;
  logic              pend;
  logic [WORD_W-1:0] pend_word;
  logic [BW-1:0]     pend_data;
  logic              beat_end;
  logic              last_beat;
  logic              unused_off;

  assign unused_off = ^miss_addr[OFF_W-1:0];
  assign beat_end   = (sub == SUB_W'(BEAT_CYC - 1));
  assign last_beat  = (beat == WORD_W'(BEATS - 1));

  assign miss_ready = (st == S_IDLE);
  assign nl_req     = (st == S_WREQ) || (st == S_RREQ && cnt == '0);
  assign nl_we      = (st == S_WREQ);
  assign nl_addr    = (st == S_WREQ) ? r_vline : r_line;
  assign nl_wput    = (st == S_WBEAT) && beat_end;
  assign nl_wdata   = drd_data;
  assign nl_rtake   = (st == S_RBEAT) && beat_end;
  assign drd_slot   = r_slot;
  assign drd_word   = beat;
  assign dwr_en     = pend;
  assign dwr_slot   = r_slot;
  assign dwr_word   = pend_word;
  assign dwr_data   = pend_data;
  assign done       = (st == S_FILL);
  assign tag_we     = done;
  assign tag_slot   = r_slot;
  assign tag_val    = r_line[LINE_W-1:SET_W];
  assign tag_valid  = 1'b1;
  assign tag_dirty  = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      sub       <= '0;
      beat      <= '0;
      r_line    <= '0;
      r_vline   <= '0;
      r_slot    <= '0;
      pend      <= 1'b0;
      pend_word <= '0;
      pend_data <= '0;
    end else begin
      pend <= nl_rtake;
      if (nl_rtake) begin
        pend_word <= beat;
        pend_data <= nl_rdata;
      end
      case (st)
        S_IDLE: if (miss_valid) begin
          r_line  <= miss_addr[ADDR_W-1:OFF_W];
          r_vline <= miss_vic_line;
          r_slot  <= miss_slot;
          cnt     <= '0;
          sub     <= '0;
          beat    <= '0;
          st      <= miss_dirty ? S_WREQ : S_RREQ;
        end
        S_WREQ: st <= S_WBEAT;
        S_RREQ: begin
          if (cnt == CNT_W'(REQ_LAT - 1)) begin
            cnt <= '0;
            st  <= S_RBEAT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WBEAT, S_RBEAT: begin
          if (beat_end) begin
            sub <= '0;
            if (last_beat) begin
              beat <= '0;
              st   <= (st == S_WBEAT) ? S_RREQ : S_FILL;
            end else begin
              beat <= beat + 1'b1;
            end
          end else begin
            sub <= sub + 1'b1;
          end
        end
        S_FILL:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> !miss_ready);
  a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    nl_req |=> !nl_req);
  a_r4_take_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    nl_rtake |=> dwr_en && dwr_data == $past(nl_rdata));
  a_r5_fill_with_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> dwr_en && dwr_word == WORD_W'(BEATS - 1));
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && miss_ready);
  a_r7_quiet_wb: assert property (@(posedge clk) disable iff (!rst_n)
    nl_wput |-> !dwr_en && !tag_we);
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> !dwr_en && !tag_we);

endmodule

// File: tb/sim_miss_refill_ctrl.sv
module sim_miss_refill_ctrl;
  localparam int LAT = 10;
  localparam int BC  = 2;
  localparam int NB  = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         miss_valid = 1'b0;
  logic         miss_ready;
  logic [31:0]  miss_addr = '0;
  logic [7:0]   miss_slot = '0;
  logic         miss_dirty = 1'b0;
  logic [25:0]  miss_vic_line = '0;
  logic         nl_req, nl_we, nl_wput, nl_rtake;
  logic [25:0]  nl_addr;
  logic [127:0] nl_wdata, nl_rdata, drd_data, dwr_data;
  logic [7:0]   drd_slot, dwr_slot, tag_slot;
  logic [1:0]   drd_word, dwr_word;
  logic         dwr_en, tag_we, tag_valid, tag_dirty, done;
  logic [19:0]  tag_val;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  miss_refill_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .miss_slot(miss_slot), .miss_dirty(miss_dirty),
    .miss_vic_line(miss_vic_line), .nl_req(nl_req), .nl_we(nl_we), .nl_addr(nl_addr),
    .nl_wput(nl_wput), .nl_wdata(nl_wdata), .nl_rtake(nl_rtake), .nl_rdata(nl_rdata),
    .drd_slot(drd_slot), .drd_word(drd_word), .drd_data(drd_data), .dwr_en(dwr_en),
    .dwr_slot(dwr_slot), .dwr_word(dwr_word), .dwr_data(dwr_data), .tag_we(tag_we),
    .tag_slot(tag_slot), .tag_val(tag_val), .tag_valid(tag_valid),
    .tag_dirty(tag_dirty), .done(done)
  );

  function automatic logic [127:0] rpat(input logic [25:0] line, input int k);
    return {4{line[23:0], 8'(k)}};
  endfunction

  function automatic logic [127:0] vpat(input logic [7:0] s, input int k);
    return {4{8'hA5, s, 8'(k), 8'h3C}};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h expected %h", rq, cyc, act, exp);
    end
  endtask

  // next-level memory and data array behaviour
  logic [25:0] mline = '0;
  int          mcnt = 0;
  always @(posedge clk) begin
    if (!rst_n) mcnt <= 0;
    else if (nl_req && !nl_we) begin mline <= nl_addr; mcnt <= 0; end
    else if (nl_rtake) mcnt <= mcnt + 1;
  end
  assign nl_rdata = rpat(mline, mcnt);
  assign drd_data = vpat(drd_slot, int'(drd_word));

  // reference model: relative cycle t since acceptance
  bit          mbusy = 0;
  int          t = 0;
  int          rr = 1;
  logic [31:0] e_addr = '0;
  logic [7:0]  e_slot = '0;
  bit          e_dirty = 0;
  logic [25:0] e_vline = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) mbusy = 0;
    else if (mbusy) begin
      if (t == rr + LAT + NB*BC) mbusy = 0;
      else t++;
    end else if (miss_valid) begin
      mbusy = 1; t = 1;
      e_addr = miss_addr; e_slot = miss_slot; e_dirty = miss_dirty; e_vline = miss_vic_line;
      rr = e_dirty ? 2 + NB*BC : 1;
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int  u, k, wk;
      bit  x_req, x_we, x_take, x_dwr, x_done, x_wput, in_wb;
      logic [25:0] x_addr;
      u      = t - rr;
      x_we   = mbusy && e_dirty && t == 1;
      x_req  = mbusy && (t == rr || x_we);
      x_addr = x_we ? e_vline : e_addr[31:6];
      x_take = mbusy && u >= LAT && u < LAT + NB*BC && ((u - LAT) % BC == BC - 1);
      x_dwr  = mbusy && u >= LAT + BC && u <= LAT + NB*BC && ((u - LAT) % BC == 0);
      k      = (u - LAT) / BC - 1;
      x_done = mbusy && u == LAT + NB*BC;
      x_wput = mbusy && e_dirty && t >= 2 && t < 2 + NB*BC && ((t - 2) % BC == BC - 1);
      wk     = (t - 2) / BC;
      in_wb  = !mbusy || t < rr;

      chk(miss_ready == !mbusy, "R1 R8 ready", 128'(miss_ready), 128'(!mbusy));
      chk(nl_req == x_req && nl_we == (x_req && x_we), x_we ? "R6 wb request" : "R2 request",
          {nl_req, nl_we}, {x_req, x_req && x_we});
      if (x_req) chk(nl_addr == x_addr, x_we ? "R6 wb address" : "R2 address", 128'(nl_addr), 128'(x_addr));
      chk(nl_rtake == x_take, "R3 take", 128'(nl_rtake), 128'(x_take));
      chk(dwr_en == x_dwr, in_wb ? "R7 no write" : "R4 write enable", 128'(dwr_en), 128'(x_dwr));
      if (x_dwr) begin
        chk(dwr_slot == e_slot && int'(dwr_word) == k, "R4 slot word", {dwr_slot, dwr_word}, {e_slot, 2'(k)});
        chk(dwr_data == rpat(e_addr[31:6], k), "R4 data", dwr_data, rpat(e_addr[31:6], k));
      end
      chk(done == x_done && tag_we == x_done, in_wb ? "R7 no tag" : "R5 done tag", {done, tag_we}, {x_done, x_done});
      if (x_done)
        chk(tag_slot == e_slot && tag_val == e_addr[31:12] && tag_valid && !tag_dirty, "R5 tag entry",
            {tag_slot, tag_val, tag_valid, tag_dirty}, {e_slot, e_addr[31:12], 2'b10});
      chk(nl_wput == x_wput, "R6 wput", 128'(nl_wput), 128'(x_wput));
      if (x_wput) begin
        chk(drd_slot == e_slot && int'(drd_word) == wk, "R6 read addr", {drd_slot, drd_word}, {e_slot, 2'(wk)});
        chk(nl_wdata == vpat(e_slot, wk), "R6 wdata", nl_wdata, vpat(e_slot, wk));
      end
    end
  end

  task automatic issue(input logic [31:0] a, input logic [7:0] s, input bit d, input logic [25:0] v);
    @(negedge clk);
    miss_valid = 1; miss_addr = a; miss_slot = s; miss_dirty = d; miss_vic_line = v;
    while (!miss_ready) @(negedge clk);
  endtask

  task automatic wait_done(output int n);
    n = 1;
    while (!done) begin @(negedge clk); n++; end
  endtask

  int n;
  int req_seen;

  initial begin
    repeat (3) @(negedge clk);
    chk(miss_ready && !nl_req && !dwr_en && !done, "R1 reset state",
        {miss_ready, nl_req, dwr_en, done}, 4'b1000);
    rst_n = 1;

    issue(32'h1234_5678, 8'd5, 0, 26'h0);
    @(negedge clk); miss_valid = 0;
    wait_done(n);
    chk(n == 1 + LAT + NB*BC, "R5 clean penalty", 128'(n), 128'(1 + LAT + NB*BC));

    issue(32'hDEAD_BEC0, 8'hFF, 1, 26'h3AB_CDEF);
    @(negedge clk); miss_valid = 0;
    wait_done(n);
    chk(n == 2 + 2*NB*BC + LAT, "R6 dirty penalty", 128'(n), 128'(2 + 2*NB*BC + LAT));

    issue(32'h0000_1040, 8'd17, 0, 26'h0);
    @(negedge clk);
    miss_addr = 32'h8765_4300; miss_slot = 8'd42; miss_dirty = 1; miss_vic_line = 26'h155_5555;
    wait_done(n);
    chk(n == 1 + LAT + NB*BC, "R8 first penalty", 128'(n), 128'(1 + LAT + NB*BC));
    @(negedge clk);
    chk(miss_ready == 1'b1, "R8 ready after done", 128'(miss_ready), 128'(1));
    @(negedge clk); miss_valid = 0;
    wait_done(n);
    chk(n == 2 + 2*NB*BC + LAT, "R8 held request penalty", 128'(n), 128'(2 + 2*NB*BC + LAT));

    issue(32'h4444_0080, 8'd3, 1, 26'h222_2222);
    @(negedge clk); miss_valid = 0;
    repeat (3) @(negedge clk);
    miss_valid = 1; miss_addr = 32'h7777_7700; miss_slot = 8'd9; miss_dirty = 0;
    repeat (5) @(negedge clk);
    miss_valid = 0;
    wait_done(n);
    req_seen = 0;
    repeat (30) begin @(negedge clk); if (nl_req) req_seen++; end
    chk(req_seen == 0, "R1 withdrawn request ignored", 128'(req_seen), 128'(0));

    issue(32'hFFFF_FFFF, 8'd0, 0, 26'h0);
    @(negedge clk); miss_valid = 0;
    wait_done(n);
    chk(n == 1 + LAT + NB*BC, "R5 all-ones address penalty", 128'(n), 128'(1 + LAT + NB*BC));

    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule